// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC and judges each frame by its destination address. Bytes arrive one per clock, qualified by a byte-valid strobe, and a start strobe marks the first byte of a frame. Over the first six qualified bytes the filter keeps running comparisons against the programmed station address and against the broadcast address. It also runs a byte-serial CRC used for the multicast hash lookup.

When the sixth byte is taken, the filter issues one verdict. Receive must be enabled. Promiscuous mode accepts anything. Otherwise the frame passes on a station match, a broadcast, or a set bit in the 64-entry multicast hash table when hashing is on. The accept flag stays valid until the next frame starts, so downstream storage logic can consult it at any time during the frame body.

Top module: `dst_addr_filter`

## Requirements
- R1: While `rx_en` is low at the clock edge that takes the sixth address byte, the verdict is a reject, even if the address matches.
- R2: With `rx_en` and `promisc` high at that edge, the verdict is an accept whatever the address.
- R3: A station match needs every address byte to equal its station byte. Byte 0 is `station_addr[0][15:8]` and byte 1 is `station_addr[0][7:0]`. Bytes 2 and 3 come from `station_addr[1]` in the same order, and bytes 4 and 5 from `station_addr[2]`. A station match is accepted.
- R4: An address of six 0xFF bytes is accepted as broadcast.
- R5: With `hash_en` high, the six address bytes feed a reflected CRC-32, bytes in arrival order and each byte least significant bit first. The CRC uses polynomial 0xEDB88320, starts from 0xFFFFFFFF and is not inverted afterwards. Its bits 31:26 form an index. The index selects bit `index[3:0]` of `hash_table[3 - index[5:4]]`, and a set bit accepts the frame.
- R6: A frame that matches neither the station address nor broadcast is rejected when `hash_en` is low or the selected hash bit is clear.
- R7: `verdict_valid` is high for exactly one cycle, right after the edge that takes the sixth byte. `verdict_accept` then holds its value until the edge that takes the next start byte, which clears it to 0.
- R8: A start byte arriving before six bytes have been taken abandons the partial address. Comparison restarts with that byte as byte 0.
- R9: Qualified bytes after the sixth byte and before the next start produce no verdict and do not change `verdict_accept`. A start strobe with `byte_valid` low is ignored.
- R10: Cycles with `byte_valid` low are gaps and do not advance the address position.
- R11: After reset, `verdict_valid` and `verdict_accept` are 0, and bytes without a preceding start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable; low rejects every frame |
| promisc | input | 1 | Promiscuous mode; accept every frame |
| hash_en | input | 1 | Enable the multicast hash lookup |
| station_addr | input | 3x16 | Station address words; word 0 holds bytes 0 and 1, high byte first |
| hash_table | input | 4x16 | Multicast hash table words; index picks word 3 - index[5:4] |
| byte_valid | input | 1 | Qualifies `byte_data` this cycle |
| sof | input | 1 | Marks the qualified byte as frame byte 0 |
| byte_data | input | 8 | Received byte |
| verdict_valid | output | 1 | One-cycle strobe after the sixth address byte |
| verdict_accept | output | 1 | Accept (1) or reject (0); held until the next start byte |

## Verification
The bench checks that the two bytes within each station word are ordered high byte first. A filter with the byte order swapped would accept the byte-swapped address and reject the true one. Both a set and a cleared hash bit are tested on a multicast address. A wrong CRC seed, a final inversion or a non-reversed word index would select another bit and flip one of those two verdicts. Partial addresses cut off by a new start, gaps inside the address, and extra bytes after it are all exercised. A filter that did not restart, that counted gap cycles, or that kept counting past byte six would give a stray verdict or the wrong one.

// File: rtl/daf_pkg.sv
// Shared constants and a CRC helper for the destination address filter.
// Assumes bytes are fed least significant bit first, as on the wire.
package daf_pkg;
    localparam int          DAF_ADDR_BYTES = 6;
    localparam int          DAF_WORD_W     = 16;
    localparam int          DAF_HASH_WORDS = 4;
    localparam int          DAF_CRC_W      = 32;
    localparam logic [31:0] DAF_CRC_POLY   = 32'hEDB8_8320;
    localparam logic [31:0] DAF_CRC_INIT   = 32'hFFFF_FFFF;
endpackage

// File: rtl/daf_crc_step.sv
// One byte of a reflected CRC update, purely combinational.
// Assumes the reflected polynomial form; no inversion is applied here.
module daf_crc_step #(
    parameter int               CRC_W = daf_pkg::DAF_CRC_W,
    parameter logic [CRC_W-1:0] POLY  = daf_pkg::DAF_CRC_POLY
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [7:0]       data_in,
    output logic [CRC_W-1:0] crc_out
);
    // Fold in the byte, then shift eight times, LSB first.
    always_comb begin
        logic [CRC_W-1:0] c;
        c = crc_in ^ {{(CRC_W-8){1'b0}}, data_in};
        for (int i = 0; i < 8; i++) begin
            if (c[0]) c = (c >> 1) ^ POLY;
            else      c = c >> 1;
        end
        crc_out = c;
    end
endmodule

// File: rtl/daf_addr_cmp.sv
// Compares one address byte with the station byte at its position, and
// with the broadcast pattern. Station bytes are packed high byte first
// within each word. Assumes pos < N_BYTES whenever the result is used.
module daf_addr_cmp #(
    parameter int N_BYTES = daf_pkg::DAF_ADDR_BYTES,
    parameter int WORD_W  = daf_pkg::DAF_WORD_W,
    localparam int BPW     = WORD_W / 8,
    localparam int N_WORDS = N_BYTES / BPW,
    localparam int POS_W   = $clog2(N_BYTES + 1)
) (
    input  logic [POS_W-1:0]               pos,
    input  logic [7:0]                     data_in,
    input  logic [N_WORDS-1:0][WORD_W-1:0] station,
    output logic                           sta_eq,
    output logic                           bc_eq
);
    localparam int WIDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
    localparam int BSEL_W = (BPW > 1) ? $clog2(BPW) : 1;

    // Pick the station byte for this position and compare.
    always_comb begin
        logic [WORD_W-1:0] w;
        int                widx;
        int                bsel;
        widx   = int'(pos) / BPW;
        bsel   = int'(pos) % BPW;
        w      = '0;
        sta_eq = 1'b0;
        if (int'(pos) < N_BYTES) begin
            w      = station[WIDX_W'(widx)];
            sta_eq = (w[(WORD_W - 1 - 8 * bsel) -: 8] == data_in);
        end
        bc_eq = (data_in == 8'hFF);
    end
    logic unused_bsel;
    assign unused_bsel = ^BSEL_W;
endmodule

// File: rtl/daf_hash_sel.sv
// Looks up one bit of the multicast hash table. The upper index bits
// choose a word counted from the top of the table, the lower ones a bit.
module daf_hash_sel #(
    parameter int N_WORDS = daf_pkg::DAF_HASH_WORDS,
    parameter int WORD_W  = daf_pkg::DAF_WORD_W,
    localparam int BIT_W  = $clog2(WORD_W),
    localparam int WSEL_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int IDX_W  = $clog2(N_WORDS * WORD_W)
) (
    input  logic [IDX_W-1:0]               idx,
    input  logic [N_WORDS-1:0][WORD_W-1:0] table_in,
    output logic                           hit
);
    // Reverse the word select, then pick the bit.
    always_comb begin
        logic [WSEL_W-1:0] wsel;
        wsel = WSEL_W'(N_WORDS - 1) - WSEL_W'(idx[IDX_W-1:BIT_W]);
        hit  = table_in[wsel][idx[BIT_W-1:0]];
    end
endmodule

// File: rtl/dst_addr_filter.sv
// Destination address filter. It tracks the byte position in the address
// and keeps running station/broadcast match flags and a CRC. It registers
// one verdict when the last address byte is taken.
// Assumes sof is only meaningful together with byte_valid.
module dst_addr_filter #(
    parameter int N_BYTES    = daf_pkg::DAF_ADDR_BYTES,
    parameter int WORD_W     = daf_pkg::DAF_WORD_W,
    parameter int HASH_WORDS = daf_pkg::DAF_HASH_WORDS,
    localparam int BPW       = WORD_W / 8,
    localparam int STA_WORDS = N_BYTES / BPW,
    localparam int CRC_W     = daf_pkg::DAF_CRC_W
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 rx_en,
    input  logic                                 promisc,
    input  logic                                 hash_en,
    input  logic [STA_WORDS-1:0][WORD_W-1:0]     station_addr,
    input  logic [HASH_WORDS-1:0][WORD_W-1:0]    hash_table,
    input  logic                                 byte_valid,
    input  logic                                 sof,
    input  logic [7:0]                           byte_data,
    output logic                                 verdict_valid,
    output logic                                 verdict_accept
);
    localparam int               POS_W = $clog2(N_BYTES + 1);
    localparam int               IDX_W = $clog2(HASH_WORDS * WORD_W);
    localparam logic [POS_W-1:0] IDLE  = POS_W'(N_BYTES);
    localparam logic [POS_W-1:0] LAST  = POS_W'(N_BYTES - 1);

    logic [POS_W-1:0] pos_q;
    logic [CRC_W-1:0] crc_q;
    logic             sta_ok_q, bc_ok_q;

    logic             start, take, last;
    logic [POS_W-1:0] cur_pos;
    logic [CRC_W-1:0] crc_base, crc_nx;
    logic             sta_eq, bc_eq, sta_nx, bc_nx, hash_hit, accept_d;

    // Decode the strobes: a start byte always restarts the address.
    always_comb begin
        start    = byte_valid && sof;
        take     = start || (byte_valid && (pos_q != IDLE));
        cur_pos  = start ? '0 : pos_q;
        last     = take && (cur_pos == LAST);
        crc_base = start ? daf_pkg::DAF_CRC_INIT : crc_q;
    end

    daf_crc_step #(.CRC_W(CRC_W), .POLY(daf_pkg::DAF_CRC_POLY)) u_crc (
        .crc_in  (crc_base),
        .data_in (byte_data),
        .crc_out (crc_nx)
    );

    daf_addr_cmp #(.N_BYTES(N_BYTES), .WORD_W(WORD_W)) u_cmp (
        .pos     (cur_pos),
        .data_in (byte_data),
        .station (station_addr),
        .sta_eq  (sta_eq),
        .bc_eq   (bc_eq)
    );

    daf_hash_sel #(.N_WORDS(HASH_WORDS), .WORD_W(WORD_W)) u_hash (
        .idx      (crc_nx[CRC_W-1 -: IDX_W]),
        .table_in (hash_table),
        .hit      (hash_hit)
    );

    // Fold this byte into the match flags and form the verdict.
    always_comb begin
        sta_nx   = (start ? 1'b1 : sta_ok_q) && sta_eq;
        bc_nx    = (start ? 1'b1 : bc_ok_q) && bc_eq;
        accept_d = rx_en && (promisc || sta_nx || bc_nx || (hash_en && hash_hit));
    end

    // Position, running flags and CRC state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= IDLE;
            crc_q    <= daf_pkg::DAF_CRC_INIT;
            sta_ok_q <= 1'b0;
            bc_ok_q  <= 1'b0;
        end else if (take) begin
            pos_q    <= cur_pos + POS_W'(1);
            crc_q    <= crc_nx;
            sta_ok_q <= sta_nx;
            bc_ok_q  <= bc_nx;
        end
    end

    // Verdict strobe and held accept flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_valid  <= 1'b0;
            verdict_accept <= 1'b0;
        end else begin
            verdict_valid <= last;
            if (last)       verdict_accept <= accept_d;
            else if (start) verdict_accept <= 1'b0;
        end
    end

    // R7: the strobe never lasts two cycles.
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |=> !verdict_valid);

    // R7: a start byte clears the held flag.
    p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && sof) |=> !verdict_accept);

    // R1: disabled receive never yields an accept.
    p_disabled_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !sof && pos_q == LAST && !rx_en) |=> !verdict_accept);

    // R2: promiscuous with receive on always accepts.
    p_promisc_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !sof && pos_q == LAST && rx_en && promisc) |=> verdict_accept);

    // R9: no verdict unless the final byte was just taken.
    p_no_stray_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == IDLE && !(byte_valid && sof)) |=> !verdict_valid);

    // R9: without a start, the flag only moves with a verdict.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(byte_valid && sof) && !(byte_valid && pos_q == LAST)) |=> $stable(verdict_accept));
endmodule

// File: tb/sim_dst_addr_filter.sv
module sim_dst_addr_filter;
    logic             clk = 1'b0;
    logic             rst_n;
    logic             rx_en, promisc, hash_en;
    logic [2:0][15:0] station_addr;
    logic [3:0][15:0] hash_table;
    logic             byte_valid, sof;
    logic [7:0]       byte_data;
    logic             verdict_valid, verdict_accept;

    int n_tests = 0;
    int n_fail  = 0;
    int stray   = 0;
    bit done    = 0;
    bit exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    dst_addr_filter u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .promisc(promisc),
        .hash_en(hash_en), .station_addr(station_addr), .hash_table(hash_table),
        .byte_valid(byte_valid), .sof(sof), .byte_data(byte_data),
        .verdict_valid(verdict_valid), .verdict_accept(verdict_accept)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Hash index: bit-serial reflected CRC, byte 0 first, LSB first.
    function automatic logic [5:0] hash_index(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int b = 0; b < 6; b++) begin
            for (int k = 0; k < 8; k++) begin
                logic fb;
                fb = c[0] ^ a[47 - 8*b - 7 + k];
                c  = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        return c[31:26];
    endfunction

    function automatic logic model(input logic [47:0] a);
        logic [5:0] ix;
        if (!rx_en) return 1'b0;
        if (promisc) return 1'b1;
        if (a == {station_addr[0], station_addr[1], station_addr[2]}) return 1'b1;
        if (a == 48'hFFFF_FFFF_FFFF) return 1'b1;
        if (!hash_en) return 1'b0;
        ix = hash_index(a);
        return hash_table[3 - ix[5:4]][ix[3:0]];
    endfunction

    // Drive n bytes of address a (byte 0 = a[47:40]); optional gaps.
    task automatic send(input logic [47:0] a, input int n, input bit gaps,
                        input string req);
        for (int i = 0; i < n; i++) begin
            if (gaps && i > 0) begin
                @(negedge clk);
                byte_valid = 0; sof = 0; byte_data = 8'h5A;
            end
            @(negedge clk);
            byte_valid = 1; sof = (i == 0); byte_data = a[47 - 8*i -: 8];
            if (i == 5) begin
                exp_q.push_back(model(a));
                tag_q.push_back(req);
            end
        end
        @(negedge clk);
        byte_valid = 0; sof = 0;
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && verdict_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                stray++;
            end else begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, verdict_accept, e);
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    localparam logic [47:0] STA = 48'h0A1B_2C3D_4E5F;
    localparam logic [47:0] MC  = 48'h0100_5E00_0001;

    initial begin
        logic [5:0] ix;
        rst_n = 0; rx_en = 0; promisc = 0; hash_en = 0;
        station_addr = {16'h4E5F, 16'h2C3D, 16'h0A1B};
        hash_table = '0;
        byte_valid = 0; sof = 0; byte_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R11 reset valid", verdict_valid, 1'b0);
        check("R11 reset accept", verdict_accept, 1'b0);
        // R11: bytes with no start are ignored.
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); byte_valid = 1; byte_data = 8'hFF;
        end
        @(negedge clk); byte_valid = 0;
        repeat (2) @(negedge clk);

        send(STA, 6, 0, "R1 disabled");                 // R1
        rx_en = 1;
        promisc = 1; send(48'h1234_5678_9ABC, 6, 0, "R2 promisc"); // R2
        promisc = 0;
        send(STA, 6, 0, "R3 station match");            // R3
        send(48'h1B0A_3D2C_5F4E, 6, 0, "R3 byte order"); // R3 swapped
        send(48'h0A1B_2C3D_4E5E, 6, 0, "R3 last byte"); // R3
        send(48'hFFFF_FFFF_FFFF, 6, 0, "R4 broadcast");  // R4
        send(48'hFFFF_FFFF_FFFE, 6, 0, "R6 near bcast");  // R6

        ix = hash_index(MC);
        hash_en = 1;
        hash_table = '0;
        hash_table[3 - ix[5:4]][ix[3:0]] = 1'b1;
        send(MC, 6, 0, "R5 hash bit set");               // R5
        hash_table = '1;
        hash_table[3 - ix[5:4]][ix[3:0]] = 1'b0;
        send(MC, 6, 0, "R5 hash bit clear");             // R5
        hash_en = 0; hash_table = '1;
        send(MC, 6, 0, "R6 hash disabled");              // R6

        send(STA, 6, 1, "R10 gaps");                     // R10
        send(48'hFFFF_FFFF_FFFF, 3, 0, "R8 partial");    // R8
        send(48'h0000_0000_0001, 6, 0, "R8 restart reject");
        send(48'h7777_7777_7777, 4, 0, "R8 partial");
        send(STA, 6, 0, "R8 restart accept");

        // R7: strobe timing and hold.
        @(negedge clk);
        byte_valid = 1; sof = 1; byte_data = STA[47:40];
        @(negedge clk);
        check("R7 start clears", verdict_accept, 1'b0);
        sof = 0;
        for (int i = 1; i < 6; i++) begin
            byte_data = STA[47 - 8*i -: 8];
            if (i == 5) begin exp_q.push_back(1'b1); tag_q.push_back("R7 value"); end
            @(negedge clk);
            if (i < 5) check("R7 no early strobe", verdict_valid, 1'b0);
        end
        check("R7 strobe on time", verdict_valid, 1'b1);
        // R9: extra bytes after the address.
        byte_data = 8'h00;
        @(negedge clk);
        check("R7 strobe one cycle", verdict_valid, 1'b0);
        repeat (6) @(negedge clk);
        byte_valid = 0;
        rx_en = 0;
        repeat (3) @(negedge clk);
        check("R9 hold accept", verdict_accept, 1'b1);
        // R9: start without byte_valid is ignored.
        sof = 1; @(negedge clk); sof = 0; @(negedge clk);
        check("R9 lone sof", verdict_accept, 1'b1);
        check("R9 no stray verdict", stray != 0, 1'b0);
        check("R9 queue drained", exp_q.size() != 0, 1'b0);
        finish_run();
    end
endmodule